// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division over many clock cycles and keeps its results in two dedicated 32-bit registers, HI and LO. A start command carries two operands and an operation code. A product places its upper word in HI and its lower word in LO. A quotient goes to LO and the remainder goes to HI. Both signed and unsigned forms exist for each operation.

The pipeline reaches the registers through move operations. A move-to strobe loads HI or LO from a general register value. A move-from request returns HI or LO on a read port. While an operation is in flight, `busy_o` is high. A move-from request during that time raises `stall_o`, so the consumer waits for the finished result.

Both datapaths retire one bit per clock. The multiplier is a shift-add design and the divider is a restoring design. Signed operands are converted to magnitudes at load time, and the signs are applied again at the last step.

Top module: `muldiv_hilo`

## Requirements
- R1: Operation code 2'b00 (signed multiply) writes the two's-complement 64-bit product of `opa_i` and `opb_i`, with bits 63:32 in HI and bits 31:0 in LO.
- R2: Operation code 2'b01 (unsigned multiply) writes the unsigned 64-bit product, with the same HI/LO placement as R1.
- R3: Operation code 2'b10 (signed divide) writes a quotient truncated toward zero to LO and a remainder carrying the dividend's sign to HI. The case 0x80000000 / -1 gives quotient 0x80000000 and remainder 0.
- R4: Operation code 2'b11 (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R5: A divide by zero, signed or unsigned, completes normally with LO = 0xFFFFFFFF and HI equal to the dividend.
- R6: A start accepted while idle holds `busy_o` high for exactly 32 cycles. The result is readable in the first cycle after `busy_o` falls.
- R7: A start asserted while `busy_o` is high is ignored. The running operation keeps its length and its result.
- R8: `rdata_o` returns HI when `mf_sel_i` is 1 and LO when it is 0. `stall_o` is high exactly when `mf_req_i` is high while `busy_o` is high.
- R9: When idle, `mt_hi_i` and `mt_lo_i` load `wdata_i` into HI and LO on the next edge. While busy, both are ignored.
- R10: After reset, HI and LO read 0 and `busy_o` and `stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start an operation |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| mt_hi_i | input | 1 | Load HI from wdata_i |
| mt_lo_i | input | 1 | Load LO from wdata_i |
| wdata_i | input | 32 | Move-to data |
| mf_req_i | input | 1 | Move-from request |
| mf_sel_i | input | 1 | 1 selects HI, 0 selects LO |
| rdata_o | output | 32 | Selected HI or LO value |
| busy_o | output | 1 | Operation in flight |
| stall_o | output | 1 | Move-from held off |

## Verification
A corrupted accumulator, remainder or sign flag stays hidden while `busy_o` is high. It first shows up at the ports as a wrong HI or LO value in the first cycle after `busy_o` falls, which is 33 clock edges after the start. A fault in the iteration counter shows up sooner, as a busy window longer or shorter than 32 cycles. A write to HI/LO that leaks during a busy window shows up as `rdata_o` changing mid-operation while the select is held still.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;
endpackage

// File: rtl/md_mul_iter.sv
module md_mul_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0]   mcand_q, mcand_d;
  logic [2*W-1:0] acc_q, acc_d, acc_nxt, res;
  logic           neg_q, neg_d;
  logic [W-1:0]   mag_a, mag_b;
  logic [W:0]     upper;

  always_comb begin
    mag_a   = (sgn_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
    mag_b   = (sgn_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;
    upper   = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
    acc_nxt = {upper, acc_q[W-1:1]};
    res     = neg_q ? (~acc_nxt + 1'b1) : acc_nxt;
    hi_o    = res[2*W-1:W];
    lo_o    = res[W-1:0];
    mcand_d = mcand_q;
    acc_d   = acc_q;
    neg_d   = neg_q;
    if (load_i) begin
      mcand_d = mag_a;
      acc_d   = {{W{1'b0}}, mag_b};
      neg_d   = sgn_i & (a_i[W-1] ^ b_i[W-1]);
    end else if (step_i) begin
      acc_d   = acc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
      neg_q   <= 1'b0;
    end else if (load_i || step_i) begin
      mcand_q <= mcand_d;
      acc_q   <= acc_d;
      neg_q   <= neg_d;
    end
  end
endmodule

// File: rtl/md_div_iter.sv
module md_div_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0] dsor_q, dsor_d, quo_q, quo_d, rem_q, rem_d;
  logic         negq_q, negq_d, negr_q, negr_d;
  logic [W-1:0] mag_a, mag_b, rem_nxt, quo_nxt;
  logic [W:0]   part, diff;
  logic         fits;

  always_comb begin
    mag_a   = (sgn_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
    mag_b   = (sgn_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;
    part    = {rem_q, quo_q[W-1]};
    diff    = part - {1'b0, dsor_q};
    fits    = part >= {1'b0, dsor_q};
    rem_nxt = fits ? diff[W-1:0] : part[W-1:0];
    quo_nxt = {quo_q[W-2:0], fits};
    hi_o    = negr_q ? (~rem_nxt + 1'b1) : rem_nxt;
    lo_o    = negq_q ? (~quo_nxt + 1'b1) : quo_nxt;
    dsor_d  = dsor_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    if (load_i) begin
      dsor_d = mag_b;
      quo_d  = mag_a;
      rem_d  = '0;
      negq_d = sgn_i & (a_i[W-1] ^ b_i[W-1]) & (|b_i);
      negr_d = sgn_i & a_i[W-1];
    end else if (step_i) begin
      quo_d  = quo_nxt;
      rem_d  = rem_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsor_q <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (load_i || step_i) begin
      dsor_q <= dsor_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      negq_q <= negq_d;
      negr_q <= negr_d;
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         mt_hi_i,
  input  logic         mt_lo_i,
  input  logic [W-1:0] wdata_i,
  input  logic         mf_req_i,
  input  logic         mf_sel_i,
  output logic [W-1:0] rdata_o,
  output logic         busy_o,
  output logic         stall_o
);
  localparam int CW = $clog2(W);

  md_op_e        op_q, op_d, op_in;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  hi_q, hi_d, lo_q, lo_d;
  logic          accept, last, step, sgn_in;
  logic [W-1:0]  mul_hi, mul_lo, div_hi, div_lo;

  assign op_in  = md_op_e'(op_i);
  assign sgn_in = (op_in == OP_MULS) || (op_in == OP_DIVS);
  assign accept = start_i & ~busy_q;
  assign step   = busy_q;
  assign last   = busy_q && (cnt_q == CW'(W-1));

  md_mul_iter #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .step_i(step), .sgn_i(sgn_in),
    .a_i(opa_i), .b_i(opb_i), .hi_o(mul_hi), .lo_o(mul_lo)
  );

  md_div_iter #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .step_i(step), .sgn_i(sgn_in),
    .a_i(opa_i), .b_i(opb_i), .hi_o(div_hi), .lo_o(div_lo)
  );

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      op_d   = op_in;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
    if (last) begin
      hi_d = op_q[1] ? div_hi : mul_hi;
      lo_d = op_q[1] ? div_lo : mul_lo;
    end else if (!busy_q) begin
      if (mt_hi_i) hi_d = wdata_i;
      if (mt_lo_i) lo_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_MULS;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign rdata_o = mf_sel_i ? hi_q : lo_q;
  assign busy_o  = busy_q;
  assign stall_o = mf_req_i & busy_q;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         mf_req_i,
  input logic         mf_sel_i,
  input logic [W-1:0] rdata_o,
  input logic         busy_o,
  input logic         stall_o
);
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy_o ? run_q + 1'b1 : 8'd0;
  end

  // R6
  start_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R6, R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == 8'(W)));

  // R7
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_q < 8'(W)));

  // R8
  stall_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (busy_o && mf_req_i));

  // R8
  stall_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_req_i && busy_o) |-> stall_o);

  // R9
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $stable(mf_sel_i)) |-> $stable(rdata_o));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mf_req_i(mf_req_i),
  .mf_sel_i(mf_sel_i), .rdata_o(rdata_o), .busy_o(busy_o), .stall_o(stall_o)
);

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb;
  logic        clk, rst_n, start, mt_hi, mt_lo, mf_req, mf_sel;
  logic [1:0]  op;
  logic [31:0] opa, opb, wdata, rdata;
  logic        busy, stall;
  int          n_chk, n_bad;
  bit          done;

  muldiv_hilo u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .opa_i(opa),
    .opb_i(opb), .mt_hi_i(mt_hi), .mt_lo_i(mt_lo), .wdata_i(wdata),
    .mf_req_i(mf_req), .mf_sel_i(mf_sel), .rdata_o(rdata), .busy_o(busy),
    .stall_o(stall)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb, sq, sr;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    case (o)
      2'b00: model = sa * sb;
      2'b01: model = {32'b0, a} * {32'b0, b};
      2'b10: begin
        if (b == 0) model = {a, 32'hFFFF_FFFF};
        else begin
          sq = sa / sb; sr = sa % sb;
          model = {sr[31:0], sq[31:0]};
        end
      end
      default: model = (b == 0) ? {a, 32'hFFFF_FFFF} : {a % b, a / b};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_hilo(output logic [31:0] h, output logic [31:0] l);
    mf_sel = 1'b1; #1; h = rdata;
    mf_sel = 1'b0; #1; l = rdata;
  endtask

  // Runs one operation; extra = 1 injects a start, move-to and move-from mid-flight
  task automatic run_op(input string req, input logic [1:0] o, input logic [31:0] a,
                        input logic [31:0] b, input bit extra);
    logic [63:0] exp;
    logic [31:0] h, l;
    int cyc;
    exp = model(o, a, b);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin
      if (extra && cyc == 5) begin
        // R7: second start ignored; R9: move-to ignored while busy
        start = 1'b1; op = ~o; opa = 32'h1234_5678; opb = 32'h3;
        mt_hi = 1'b1; mt_lo = 1'b1; wdata = 32'hDEAD_BEEF;
        mf_req = 1'b1; #1;
        check("R8 stall", {31'b0, stall}, 32'd1);
      end else begin
        start = 1'b0; mt_hi = 1'b0; mt_lo = 1'b0; mf_req = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; mt_hi = 1'b0; mt_lo = 1'b0;
    mf_req = 1'b1; #1;
    check("R8 no stall idle", {31'b0, stall}, 32'd0);
    mf_req = 1'b0;
    check({req, " R6 busy cycles"}, cyc, 32'd32);
    read_hilo(h, l);
    check({req, " HI"}, h, exp[63:32]);
    check({req, " LO"}, l, exp[31:0]);
  endtask

  initial begin
    logic [31:0] h, l;
    int unsigned seed;
    n_chk = 0; n_bad = 0; done = 0;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; start = 0; op = 0; opa = 0; opb = 0;
    mt_hi = 0; mt_lo = 0; wdata = 0; mf_req = 0; mf_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_hilo(h, l);
    check("R10 HI reset", h, 32'd0);
    check("R10 LO reset", l, 32'd0);
    check("R10 busy reset", {31'b0, busy}, 32'd0);

    // R9 move-to while idle
    @(negedge clk); mt_hi = 1; wdata = 32'hA5A5_0001;
    @(negedge clk); mt_hi = 0; mt_lo = 1; wdata = 32'h0000_5A5A;
    @(negedge clk); mt_lo = 0;
    read_hilo(h, l);
    check("R9 HI written", h, 32'hA5A5_0001);
    check("R9 LO written", l, 32'h0000_5A5A);

    run_op("R1", 2'b00, 32'hFFFF_FFF9, 32'd6, 0);
    run_op("R1", 2'b00, 32'h8000_0000, 32'h8000_0000, 0);
    run_op("R2", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_op("R3", 2'b10, 32'hFFFF_FFF9, 32'd2, 0);
    run_op("R3", 2'b10, 32'd7, 32'hFFFF_FFFE, 0);
    run_op("R3", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_op("R4", 2'b11, 32'hFFFF_FFFF, 32'd10, 0);
    run_op("R5", 2'b10, 32'hFFFF_FF00, 32'd0, 0);
    run_op("R5", 2'b11, 32'd12345, 32'd0, 0);
    run_op("R7 R9", 2'b01, 32'd1000, 32'd77, 1);
    run_op("R7 R9", 2'b10, 32'hFFFF_0000, 32'd9, 1);

    for (int i = 0; i < 40; i++) begin
      logic [1:0] ro;
      logic [31:0] ra, rb;
      ro = 2'($urandom);
      ra = $urandom;
      rb = (i % 4 == 0) ? 32'($urandom % 16) : $urandom;
      run_op(ro[1] ? (ro[0] ? "R4 rnd" : "R3 rnd") : (ro[0] ? "R2 rnd" : "R1 rnd"),
             ro, ra, rb, (i % 7) == 3);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule